// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor Core

This block is a 16-bit processor core with one instruction: subtract one memory word from another, store the difference, and branch when the difference is zero or negative. Each instruction is three consecutive words: source address `a`, destination address `b` and branch target `c`. The core drives a single-port synchronous word memory with one cycle of read latency. That memory sits outside the core, so the surrounding design chooses its depth and how it is loaded.

The all-ones address is reserved for byte I/O. An all-ones `a` reads one byte from the input handshake into `mem[b]`. Otherwise an all-ones `b` sends the low byte of `mem[a]` to the output handshake. The core stops for good once the program counter goes negative. A pause input holds the core at an instruction boundary. The `blocked` status shows that the core is paused or waiting on I/O, and the `halted` status shows that it has stopped.

Top module: `subleq_core`

## Requirements
- R1: After reset, `halted`, `blocked`, `out_wr`, `in_take` and `mem_we` are all 0, and execution begins at address 0.
- R2: For an ordinary instruction, `mem[b]` is replaced by `mem[b] - mem[a]` modulo 2^16. That write is the only memory write of the instruction.
- R3: If the difference is zero or has bit 15 set, execution continues at `c`. Otherwise it continues at the instruction three words on.
- R4: If `a` is 0xFFFF, the core waits with `blocked` high while `in_have` is 0. It then writes `in_data` zero-extended to 16 bits into `mem[b]`, pulses `in_take` for one cycle, and continues three words on.
- R5: If `a` is not 0xFFFF and `b` is 0xFFFF, the core waits with `blocked` high while `out_busy` is 1. It then presents bits 7:0 of `mem[a]` on `out_data` with a one-cycle `out_wr` pulse and continues three words on.
- R6: When the program counter is negative (bit 15 set) at an instruction boundary, `halted` rises and stays high until reset. After that there are no further memory writes and no output strobes.
- R7: While `pause` is high at an instruction boundary, the core holds there with `blocked` high. It makes no memory writes and no output. It resumes when `pause` falls.
- R8: Starting from reset, an ordinary instruction that does not branch takes 6 cycles, one that branches takes 7, and an output instruction with the output free takes 4. The cycle out of reset adds one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause | input | 1 | Hold at the next instruction boundary |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 8 | Input byte |
| in_have | input | 1 | Input byte available |
| in_take | output | 1 | One-cycle pulse: input byte consumed |
| out_data | output | 8 | Output byte |
| out_wr | output | 1 | One-cycle pulse: output byte valid |
| out_busy | input | 1 | Output sink cannot accept a byte |
| halted | output | 1 | Core has stopped |
| blocked | output | 1 | Core is paused or waiting on I/O |

## Verification
The bench builds the core with its default 16-bit word and 8-bit byte widths. With those widths the wrap boundaries sit at 0x8000 and 0xFFFF and can be reached with small literal programs. The bench models an 8192-word memory of its own. It runs short programs that cover a plain subtract, subtraction that wraps across the sign bit, a branch on a zero or negative result, echo of input bytes, a stalled output, a pause held from reset, and halting through a jump to 0xFFFF. The cycle count from reset to halt is checked against the per-instruction state counts.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_OPND_A,
    ST_OPND_B,
    ST_STORE,
    ST_JUMP,
    ST_LINK,
    ST_SKIP,
    ST_INPUT,
    ST_OUTPUT,
    ST_HALT
  } cpu_state_t;

endpackage

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
  import subleq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pause,
  input  logic       pc_neg,
  input  logic       rd_is_io,
  input  logic       diff_leq,
  input  logic       in_have,
  input  logic       out_busy,
  output cpu_state_t state,
  output logic       store_byte
);

  cpu_state_t state_q, state_d;
  logic       from_input_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BOOT:    state_d = ST_FETCH_A;
      ST_FETCH_A: begin
        if (pc_neg)     state_d = ST_HALT;
        else if (pause) state_d = ST_FETCH_A;
        else            state_d = ST_FETCH_B;
      end
      ST_FETCH_B: state_d = rd_is_io ? ST_INPUT : ST_OPND_A;
      ST_OPND_A:  state_d = rd_is_io ? ST_OUTPUT : ST_OPND_B;
      ST_OPND_B:  state_d = ST_STORE;
      ST_STORE: begin
        if (from_input_q)  state_d = ST_SKIP;
        else if (diff_leq) state_d = ST_JUMP;
        else               state_d = ST_SKIP;
      end
      ST_JUMP:    state_d = ST_LINK;
      ST_LINK:    state_d = ST_FETCH_A;
      ST_SKIP:    state_d = ST_FETCH_A;
      ST_INPUT:   state_d = in_have ? ST_STORE : ST_INPUT;
      ST_OUTPUT:  state_d = out_busy ? ST_OUTPUT : ST_FETCH_A;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_BOOT;
      from_input_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      from_input_q <= (state_q == ST_INPUT);
    end
  end

  assign state      = state_q;
  assign store_byte = from_input_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R6
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst) (state_q == ST_FETCH_A && pause && !pc_neg) |=> (state_q == ST_FETCH_A)); // R7
  AST_INPUT_WAIT: assert property (@(posedge clk) disable iff (rst) (state_q == ST_INPUT && !in_have) |=> (state_q == ST_INPUT)); // R4
  AST_OUTPUT_WAIT: assert property (@(posedge clk) disable iff (rst) (state_q == ST_OUTPUT && out_busy) |=> (state_q == ST_OUTPUT)); // R5

endmodule

// File: rtl/subleq_datapath.sv
module subleq_datapath
  import subleq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cpu_state_t        state,
  input  logic              store_byte,
  input  logic              in_have,
  input  logic              out_busy,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              pc_neg,
  output logic              rd_is_io,
  output logic              diff_leq
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(3);
  localparam logic [WORD_W-1:0] ONE  = WORD_W'(1);
  localparam logic [WORD_W-1:0] TWO  = WORD_W'(2);
  localparam int                PAD  = WORD_W - BYTE_W;

  logic [WORD_W-1:0] pc_q, a_q, b_q, opa_q, byte_q;
  logic [WORD_W-1:0] diff;

  assign diff     = mem_rdata - opa_q;
  assign diff_leq = diff[WORD_W-1] | (diff == '0);
  assign rd_is_io = &mem_rdata;
  assign pc_neg   = pc_q[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      opa_q  <= '0;
      byte_q <= '0;
    end else begin
      case (state)
        ST_BOOT:   pc_q  <= '0;
        ST_FETCH_B: a_q  <= mem_rdata;
        ST_OPND_A: b_q   <= mem_rdata;
        ST_OPND_B: opa_q <= mem_rdata;
        ST_SKIP:   pc_q  <= pc_q + STEP;
        ST_LINK:   pc_q  <= mem_rdata;
        ST_INPUT: begin
          b_q <= mem_rdata;
          if (in_have) byte_q <= {{PAD{1'b0}}, in_data};
        end
        ST_OUTPUT: if (!out_busy) pc_q <= pc_q + STEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_addr  = pc_q;
    mem_we    = 1'b0;
    mem_wdata = diff;
    case (state)
      ST_FETCH_B: mem_addr = pc_q + ONE;
      ST_INPUT:   mem_addr = pc_q + ONE;
      ST_OPND_A:  mem_addr = a_q;
      ST_OUTPUT:  mem_addr = a_q;
      ST_OPND_B:  mem_addr = b_q;
      ST_JUMP:    mem_addr = pc_q + TWO;
      ST_STORE: begin
        mem_addr  = b_q;
        mem_we    = 1'b1;
        mem_wdata = store_byte ? byte_q : diff;
      end
      default: ;
    endcase
  end

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R2
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst) (state == ST_SKIP) |=> (pc_q == $past(pc_q) + STEP)); // R3
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst) (mem_we && store_byte) |-> (mem_wdata[WORD_W-1:BYTE_W] == '0)); // R4

endmodule

// File: rtl/subleq_io.sv
module subleq_io
  import subleq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cpu_state_t        state,
  input  logic              in_have,
  input  logic              out_busy,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              in_take,
  output logic              out_wr,
  output logic [BYTE_W-1:0] out_data
);

  logic              take_q, wr_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      take_q <= (state == ST_INPUT) && in_have;
      wr_q   <= (state == ST_OUTPUT) && !out_busy;
      if ((state == ST_OUTPUT) && !out_busy) data_q <= rd_byte;
    end
  end

  assign in_take  = take_q;
  assign out_wr   = wr_q;
  assign out_data = data_q;

  AST_OUT_WHEN_FREE: assert property (@(posedge clk) disable iff (rst) out_wr |-> $past(!out_busy)); // R5
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst) out_wr |=> !out_wr); // R5
  AST_TAKE_WHEN_HAVE: assert property (@(posedge clk) disable iff (rst) in_take |-> $past(in_have)); // R4

endmodule

// File: rtl/subleq_core.sv
module subleq_core
  import subleq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_have,
  output logic              in_take,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_wr,
  input  logic              out_busy,
  output logic              halted,
  output logic              blocked
);

  cpu_state_t state;
  logic       store_byte, pc_neg, rd_is_io, diff_leq;

  subleq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pause      (pause),
    .pc_neg     (pc_neg),
    .rd_is_io   (rd_is_io),
    .diff_leq   (diff_leq),
    .in_have    (in_have),
    .out_busy   (out_busy),
    .state      (state),
    .store_byte (store_byte)
  );

  subleq_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .store_byte (store_byte),
    .in_have    (in_have),
    .out_busy   (out_busy),
    .in_data    (in_data),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .pc_neg     (pc_neg),
    .rd_is_io   (rd_is_io),
    .diff_leq   (diff_leq)
  );

  subleq_io #(.BYTE_W(BYTE_W)) u_io (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .in_have  (in_have),
    .out_busy (out_busy),
    .rd_byte  (mem_rdata[BYTE_W-1:0]),
    .in_take  (in_take),
    .out_wr   (out_wr),
    .out_data (out_data)
  );

  assign halted  = (state == ST_HALT);
  assign blocked = ((state == ST_FETCH_A) && pause && !pc_neg) ||
                   ((state == ST_INPUT) && !in_have) ||
                   ((state == ST_OUTPUT) && out_busy);

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst) halted |-> (!mem_we && !out_wr)); // R6

endmodule

// File: tb/tb_subleq_core.sv
module tb_subleq_core;

  localparam logic [15:0] IO = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pause = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  in_data = 8'h00;
  logic        in_have = 1'b0;
  logic        in_take;
  logic [7:0]  out_data;
  logic        out_wr;
  logic        out_busy = 1'b0;
  logic        halted, blocked;

  logic        ld_en = 1'b0;
  logic [12:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [0:8191];

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int halt_writes = 0;
  int early_out = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  subleq_core dut (
    .clk(clk), .rst(rst), .pause(pause),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_data(in_data), .in_have(in_have), .in_take(in_take),
    .out_data(out_data), .out_wr(out_wr), .out_busy(out_busy),
    .halted(halted), .blocked(blocked)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[12:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[12:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the core strobes a byte
  always @(negedge clk) begin
    cycles++;
    if (halted && (mem_we || out_wr)) halt_writes++;
    if (!rst && out_wr) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected output", {24'h0, out_data}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R5 output byte", {24'h0, out_data}, {24'h0, e});
      end
    end
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic poke(input int a, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 13'(a); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_out(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int i = 0; i < 48; i++) poke(i, 16'h0);
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_halt(input int limit, output int n);
    n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(halted, "R6 halt reached", {31'h0, halted}, 1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    int n;
    @(negedge clk);
    in_data = b; in_have = 1'b1;
    n = 0;
    while (!in_take && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(in_take, "R4 in_take pulse", {31'h0, in_take}, 1);
    in_have = 1'b0;
  endtask

  task automatic load_prog_a();
    clear_mem();
    poke(0, 16'd12); poke(1, 16'd13); poke(2, 16'd3);
    poke(3, 16'd13); poke(4, IO);     poke(5, 16'd6);
    poke(6, 16'd14); poke(7, 16'd14); poke(8, IO);
    poke(12, 16'd3); poke(13, 16'd10); poke(14, 16'd5);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);

    // Test A: plain subtract, output, halt; reset state and cycle count
    load_prog_a();
    @(negedge clk);
    chk(!halted && !blocked && !out_wr && !in_take && !mem_we, "R1 reset outputs",
        {27'h0, halted, blocked, out_wr, in_take, mem_we}, 0);
    expect_out(8'h07);
    release_rst();
    n = 0;
    while (!halted && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(n == 19, "R8 cycles to halt", n, 19);
    chk(mem[13] == 16'd7, "R2 subtract result", mem[13], 7);
    chk(mem[14] == 16'd0, "R3 zero result branches to halt", mem[14], 0);
    chk(exp_q.size() == 0, "R5 output delivered", exp_q.size(), 0);
    repeat (50) @(negedge clk);
    chk(halted, "R6 halt sticky", {31'h0, halted}, 1);
    chk(halt_writes == 0, "R6 no activity after halt", halt_writes, 0);

    // Test B: wrap across sign bit, branch on negative
    clear_mem();
    poke(0, 16'd20); poke(1, 16'd21); poke(2, 16'd99);
    poke(3, 16'd20); poke(4, 16'd22); poke(5, 16'd9);
    poke(6, 16'd21); poke(7, IO);     poke(8, IO);
    poke(9, 16'd22); poke(10, IO);    poke(11, 16'd12);
    poke(12, 16'd23); poke(13, 16'd23); poke(14, IO);
    poke(20, 16'd1); poke(21, 16'h8000); poke(22, 16'h0000);
    expect_out(8'hFF);
    release_rst();
    wait_halt(500, n);
    chk(mem[21] == 16'h7FFF, "R2 wrap to positive", mem[21], 16'h7FFF);
    chk(mem[22] == 16'hFFFF, "R2 wrap to negative", mem[22], 16'hFFFF);
    chk(exp_q.size() == 0, "R3 branch skipped instruction", exp_q.size(), 0);

    // Test C: input echo with waiting
    clear_mem();
    poke(0, IO);      poke(1, 16'd30);  poke(2, 16'd3);
    poke(3, 16'd30);  poke(4, IO);      poke(5, 16'd6);
    poke(6, IO);      poke(7, 16'd31);  poke(8, 16'd9);
    poke(9, 16'd31);  poke(10, IO);     poke(11, 16'd12);
    poke(12, 16'd32); poke(13, 16'd32); poke(14, IO);
    poke(30, 16'hFFFF); poke(31, 16'hFFFF);
    expect_out(8'hA5); expect_out(8'h3C);
    release_rst();
    repeat (30) @(negedge clk);
    chk(blocked, "R4 blocked while waiting input", {31'h0, blocked}, 1);
    chk(mem[30] == 16'hFFFF, "R4 no write before byte", mem[30], 16'hFFFF);
    send_byte(8'hA5);
    send_byte(8'h3C);
    wait_halt(2000, n);
    chk(mem[30] == 16'h00A5, "R4 zero-extended byte", mem[30], 16'h00A5);
    chk(mem[31] == 16'h003C, "R4 second byte", mem[31], 16'h003C);
    chk(exp_q.size() == 0, "R5 echoed bytes", exp_q.size(), 0);

    // Test D: output stalled by busy
    load_prog_a();
    out_busy = 1'b1;
    expect_out(8'h07);
    release_rst();
    repeat (60) @(negedge clk);
    chk(blocked, "R5 blocked while busy", {31'h0, blocked}, 1);
    chk(exp_q.size() == 1, "R5 no strobe while busy", exp_q.size(), 1);
    out_busy = 1'b0;
    wait_halt(500, n);
    chk(exp_q.size() == 0, "R5 strobe after busy drops", exp_q.size(), 0);

    // Test E: pause held from reset
    load_prog_a();
    pause = 1'b1;
    expect_out(8'h07);
    release_rst();
    repeat (30) @(negedge clk);
    chk(blocked && !halted, "R7 paused and blocked", {30'h0, blocked, halted}, 2);
    chk(mem[13] == 16'd10, "R7 no write while paused", mem[13], 10);
    chk(exp_q.size() == 1, "R7 no output while paused", exp_q.size(), 1);
    pause = 1'b0;
    wait_halt(500, n);
    chk(mem[13] == 16'd7, "R7 resumes after pause", mem[13], 7);
    chk(exp_q.size() == 0, "R7 output after resume", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule